// File: doc/BRIEF.md
# Infrared Serial Pulse Encoder and Decoder

This block connects a UART-style serial bit stream to a low-speed infrared transceiver. On the transmit side, each zero bit becomes one short light pulse at the start of its bit period, and each one bit sends no light at all. The pulse width is set by a static select input. It is either three sixteenths of a bit period or a fixed 1.6 µs. The fixed width is counted in system clocks, so it stays the same at every bit rate.

On the receive side, the raw infrared line may be inverted first. Each detected pulse is then stretched into a full low bit for a downstream UART receiver, and the output idles high. When the transmitter reports busy, the receiver is switched off unless full-duplex operation or loopback is selected. While it is switched off, its output is held high and any bit in progress is thrown away.

All timing comes from a one-clock enable tick at sixteen times the bit rate. The transmit bit period starts at the first tick after the busy indication rises.

Top module: `irda_sir_phy`

## Requirements
- R1: After reset, `ir_tx` is 0 and `rx_bit` is 1.
- R2: While `tx_busy` is 1, bit periods are 16 ticks long, and the first one begins at the first tick after `tx_busy` rises. If `tx_bit` is 0 at the start of a bit period, a pulse on `ir_tx` (active high) begins at that tick. If `tx_bit` is 1, no pulse is sent. Pulses therefore repeat every 16 tick periods for a run of zero bits.
- R3: With `pulse_sel` = 0, each pulse lasts exactly 3 tick periods.
- R4: With `pulse_sel` = 1, each pulse lasts ceil(1.6 µs × CLK_HZ) clocks, which is 200 clocks at 125 MHz, whatever the tick rate.
- R5: While `tx_busy` is 0, no new pulse starts, whatever `tx_bit` is.
- R6: A rising edge of the receive line (after optional inversion) drives `rx_bit` to 0 on the second clock edge after the edge. `rx_bit` stays 0 until the 16th tick after that and then returns to 1.
- R7: With `rx_inv` = 1, the receive line is `ir_rx` inverted. A pulse is then a 1-to-0 transition on `ir_rx`. With `rx_inv` = 0, the line is `ir_rx` unchanged.
- R8: With `full_duplex` = 0 and `loopback` = 0, `rx_bit` is held at 1 for as long as `tx_busy` is 1. A stretched low bit in progress is cut off at the next clock edge, and a pulse that arrives during this time is discarded.
- R9: With `full_duplex` = 1, or with `loopback` = 1, the receiver works normally while `tx_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-clock enable at 16 times the bit rate |
| tx_bit | input | 1 | Serial transmit data bit |
| tx_busy | input | 1 | Transmitter is sending a frame |
| loopback | input | 1 | Loopback channel mode; forces full duplex |
| pulse_sel | input | 1 | 0: 3/16-bit pulse, 1: fixed 1.6 µs pulse |
| rx_inv | input | 1 | Invert the raw receive line |
| full_duplex | input | 1 | Keep the receiver enabled while transmitting |
| ir_rx | input | 1 | Raw infrared receive line |
| ir_tx | output | 1 | Infrared transmit pulse, active high |
| rx_bit | output | 1 | Stretched UART-compatible receive stream |

## Verification
The hardest case to reach from the ports is a stretched low bit that is cut short by gating. To get there, the stimulus first opens the receiver with `tx_busy` low and sends a pulse. It then raises `tx_busy` partway through the stretched bit, and checks that `rx_bit` is back high one clock later. The fixed-width mode is exercised at two tick periods, 13 and 20 clocks, to show that the width does not follow the bit rate. The 13-clock tick is the shortest period at which 1.6 µs still fits inside one bit.

// File: rtl/irda_sir_phy.sv
module irda_sir_phy #(
  parameter longint CLK_HZ = 125_000_000,
  parameter int     CW     = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic tx_bit,
  input  logic tx_busy,
  input  logic loopback,
  input  logic pulse_sel,
  input  logic rx_inv,
  input  logic full_duplex,
  input  logic ir_rx,
  output logic ir_tx,
  output logic rx_bit
);

  localparam longint FIX_L   = (CLK_HZ * 16 + 64'd9_999_999) / 64'd10_000_000;
  localparam int     FIX_CYC = int'(FIX_L);

  initial assert_fix_fits_R4: assert (FIX_CYC >= 1 && FIX_CYC < (1 << CW));

  // transmit
  logic [3:0]    ph;
  logic          act, pmode;
  logic [CW-1:0] cnt;

  wire start = tick16 && tx_busy && (ph == 4'd0) && !tx_bit && !act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= 4'd0;
      act   <= 1'b0;
      pmode <= 1'b0;
      cnt   <= '0;
    end else begin
      if (!tx_busy)    ph <= 4'd0;
      else if (tick16) ph <= ph + 4'd1;
      if (start) begin
        act   <= 1'b1;
        pmode <= pulse_sel;
        cnt   <= pulse_sel ? CW'(FIX_CYC - 1) : CW'(2);
      end else if (act && (pmode || tick16)) begin
        if (cnt == '0) act <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
    end
  end

  assign ir_tx = act;

  // receive
  wire rx_line = ir_rx ^ rx_inv;
  wire rx_en   = full_duplex | loopback | !tx_busy;

  logic       s1, s2, rx_low;
  logic [3:0] rcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      rx_low <= 1'b0;
      rcnt   <= 4'd0;
    end else begin
      s1 <= rx_line;
      s2 <= s1;
      if (!rx_en) begin
        rx_low <= 1'b0;
        rcnt   <= 4'd0;
      end else if (!rx_low && s1 && !s2) begin
        rx_low <= 1'b1;
        rcnt   <= 4'd15;
      end else if (rx_low && tick16) begin
        if (rcnt == 4'd0) rx_low <= 1'b0;
        else              rcnt   <= rcnt - 4'd1;
      end
    end
  end

  assign rx_bit = !rx_low;

  assert_tx_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !ir_tx) |=> !ir_tx);

  assert_tx_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> ($past(tick16) && !$past(tx_bit)));

  assert_fix_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act && pmode && cnt != '0) |=> ir_tx);

  assert_rx_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !full_duplex && !loopback) |=> rx_bit);

  assert_rx_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_bit) |-> $past(full_duplex || loopback || !tx_busy));

endmodule

// File: tb/sim_irda_sir_phy.sv
`timescale 1ns/1ps
module sim_irda_sir_phy;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
  logic tx_bit = 1'b1, tx_busy = 1'b0, loopback = 1'b0, pulse_sel = 1'b0;
  logic rx_inv = 1'b0, full_duplex = 1'b0, ir_rx = 1'b0;
  logic ir_tx, rx_bit;
  int checks = 0, failures = 0, tp = 13;
  bit done = 0;

  irda_sir_phy u0 (.clk(clk), .rst_n(rst_n), .tick16(tick16), .tx_bit(tx_bit),
    .tx_busy(tx_busy), .loopback(loopback), .pulse_sel(pulse_sel), .rx_inv(rx_inv),
    .full_duplex(full_duplex), .ir_rx(ir_rx), .ir_tx(ir_tx), .rx_bit(rx_bit));

  always #4 clk = ~clk;

  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1 >= tp) ? 0 : c + 1;
      tick16 = (c == 0);
    end
  end

  // sel, tick period, tx bit, expected width
  localparam int V [6][4] = '{
    '{0, 13, 0, 39}, '{1, 13, 0, 200}, '{0, 20, 0, 60},
    '{1, 20, 0, 200}, '{0, 13, 1, 0},  '{1, 20, 1, 0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_vec(input int sel, input int tper, input int b, input int expw);
    int k, w, p;
    bit seen;
    pulse_sel = sel[0]; tp = tper; tx_bit = b[0];
    clocks(2);
    tx_busy = 1'b1;
    if (b == 0) begin
      k = 0;
      while (!ir_tx && k < 40 * tper) begin @(negedge clk); k++; end
      w = 0; p = 0;
      while (ir_tx && w < 1000) begin w++; @(negedge clk); p++; end
      if (sel == 0) chk(w == expw, "R3 width", w, expw);
      else          chk(w == expw, "R4 width", w, expw);
      while (!ir_tx && p < 40 * tper) begin @(negedge clk); p++; end
      chk(p == 16 * tper, "R2 period", p, 16 * tper);
    end else begin
      seen = 0;
      for (int i = 0; i < 40 * tper; i++) begin @(negedge clk); seen |= ir_tx; end
      chk(!seen, "R2 one bit no pulse", seen, 0);
    end
    tx_busy = 1'b0;
    for (int i = 0; i < 400 && ir_tx; i++) @(negedge clk);
    clocks(4);
  endtask

  task automatic rx_pulse(input string req, input bit expect_low);
    int lo;
    ir_rx = ~ir_rx;
    clocks(2);
    chk(rx_bit == !expect_low, req, rx_bit, !expect_low);
    clocks(3);
    ir_rx = ~ir_rx;
    lo = 3;
    for (int i = 0; i < 1000 && !rx_bit; i++) begin @(negedge clk); lo++; end
    if (expect_low)
      chk(lo > 15 * tp && lo <= 16 * tp, "R6 stretch length", lo, 16 * tp);
    clocks(tp * 2);
  endtask

  initial begin
    int lo;
    clocks(3);
    chk(ir_tx == 1'b0, "R1 ir_tx", ir_tx, 0);
    chk(rx_bit == 1'b1, "R1 rx_bit", rx_bit, 1);
    rst_n = 1'b1;
    clocks(2);
    chk(ir_tx == 1'b0 && rx_bit == 1'b1, "R1 after release", {ir_tx, rx_bit}, 1);

    for (int v = 0; v < 6; v++) run_vec(V[v][0], V[v][1], V[v][2], V[v][3]);

    // R5: not busy, zero bits
    tp = 13; tx_bit = 1'b0;
    begin
      bit seen = 0;
      for (int i = 0; i < 40 * 13; i++) begin @(negedge clk); seen |= ir_tx; end
      chk(!seen, "R5 idle no pulse", seen, 0);
    end
    tx_bit = 1'b1;

    // R6: plain receive
    rx_pulse("R6 low after pulse", 1'b1);
    // R8: gated while busy
    tx_busy = 1'b1;
    rx_pulse("R8 gated pulse ignored", 1'b0);
    clocks(2);
    tx_busy = 1'b0;
    clocks(4);
    chk(rx_bit == 1'b1, "R8 pulse discarded", rx_bit, 1);
    // R9: full duplex and loopback
    tx_busy = 1'b1; full_duplex = 1'b1;
    rx_pulse("R9 full duplex receive", 1'b1);
    full_duplex = 1'b0; loopback = 1'b1;
    rx_pulse("R9 loopback receive", 1'b1);
    loopback = 1'b0; tx_busy = 1'b0;
    // R7: inverted line
    rx_inv = 1'b1; ir_rx = 1'b1;
    clocks(4);
    chk(rx_bit == 1'b1, "R7 inverted idle", rx_bit, 1);
    rx_pulse("R7 inverted pulse", 1'b1);
    rx_inv = 1'b0; ir_rx = 1'b0;
    clocks(4);
    // R8: cut a stretch short
    ir_rx = 1'b1;
    clocks(2);
    chk(rx_bit == 1'b0, "R8 stretch started", rx_bit, 0);
    ir_rx = 1'b0;
    clocks(30);
    tx_busy = 1'b1;
    clocks(1);
    chk(rx_bit == 1'b1, "R8 stretch cut", rx_bit, 1);
    tx_busy = 1'b0;
    lo = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!rx_bit) lo++; end
    chk(lo == 0, "R8 no resume", lo, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule